// File: doc/BRIEF.md
# Compact-Encoding Register ALU Executor

This block runs the sixteen two-register data-processing operations of a 16-bit compressed instruction set. It is given the instruction halfword, the values of its two source registers and the current condition flags. It returns the result, a destination write enable and index, the next flags, and the number of cycles the operation costs. It presents the two register indices to the register file without delay. It takes no part in fetch, memory access or register storage.

A request is accepted on any cycle in which `req_valid` is high. The response appears on the registered outputs on the following cycle, marked by `rsp_valid`. The cycle cost includes the internal cycles used by shifts whose amount comes from a register, and by multiply. The `variant` input selects between two core flavours. They differ in multiply timing and in what multiply does to the carry flag.

Top module: `cmpx_alu_exec`

## Requirements
- R1: The operation is selected by `instr[9:6]`: 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. For the non-arithmetic, non-shift ops the result is: opa&opb, opa^opb, opa|opb, opa&~opb, ~opb (MVN), and the low 32 bits of opa*opb (MUL). TST computes opa&opb.
- R2: `ra_idx` equals `instr[2:0]` (destination and first operand). `rb_idx` equals `instr[5:3]` (second operand). Both are combinational. `wr_idx` is the registered copy of `instr[2:0]`.
- R3: Shift amounts are taken from `opb[7:0]` only. LSL or LSR by 1..31 gives carry = last bit shifted out. LSL by 32 gives result 0 with C = opa bit 0. LSR by 32 gives result 0 with C = opa bit 31. Either shift by more than 32 gives result 0 with C = 0. ASR by 32 or more fills the result and C with opa bit 31. ROR rotates by the amount mod 32, and C = result bit 31.
- R4: ADC computes opa+opb+C. SBC computes opa-opb-(1-C). CMP computes opa-opb. CMN computes opa+opb. NEG computes 0-opb. For all of these, C is the carry out (C = no borrow for subtracts) and V is signed overflow of the full operation.
- R5: TST, CMP and CMN never raise `wr_en`. Every other operation raises it with its response.
- R6: Flags are packed as N=bit 3, Z=bit 2, C=bit 1, V=bit 0. Every operation sets N from result bit 31 and Z from a zero result. V is kept for every operation outside R4. C is kept for the logical ops, and for MUL when `variant` is 0.
- R7: The cost is 1 cycle, or 2 cycles for LSL, LSR, ASR and ROR.
- R8: When `variant` is 0, MUL costs 4 cycles.
- R9: When `variant` is 1, MUL costs 5, 4, 3 or 2 cycles when the highest nonzero byte of opa is byte 3, 2, 1, or byte 0 / none. It also clears C.
- R10: `req_ready` is always high. Each accepted request yields `rsp_valid` on the next cycle only. With no request, `rsp_valid` and `wr_en` are low. After reset, `rsp_valid`, `wr_en` and `result` are 0.
- R11: A shift or rotate whose amount `opb[7:0]` is 0 returns opa unchanged and keeps C. This holds even if the higher bits of opb are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always ready |
| instr | input | 16 | Instruction halfword |
| variant | input | 1 | Core flavour for multiply |
| flags_in | input | 4 | Current N,Z,C,V |
| opa | input | 32 | Value of register `ra_idx` |
| opb | input | 32 | Value of register `rb_idx` |
| ra_idx | output | 3 | First operand / destination index |
| rb_idx | output | 3 | Second operand index |
| rsp_valid | output | 1 | Response strobe |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 3 | Destination index |
| flags_out | output | 4 | Next N,Z,C,V |
| cycles | output | 4 | Cycle cost |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-response relation;
- the absence of writes for the compare-type operations;
- preservation of V by logical operations;
- the carry clear and fixed cost of the two multiply flavours;
- the pass-through of a zero shift amount.

The exact arithmetic cannot be seen by a single-cycle property. This covers the shift corner amounts 32 and above, two-stage carry and overflow for ADC/SBC, NEG of the most negative value, and the byte-dependent multiply cost. These are shown only by the bench scenarios, which compare each response against a behavioural model.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
   typedef enum logic [3:0] {
      OP_AND    = 4'd0,  OP_XOR   = 4'd1,  OP_SHL   = 4'd2,  OP_SHR   = 4'd3,
      OP_SAR    = 4'd4,  OP_ADDC  = 4'd5,  OP_SUBC  = 4'd6,  OP_ROT   = 4'd7,
      OP_TEST   = 4'd8,  OP_NEGATE= 4'd9,  OP_COMP  = 4'd10, OP_COMPN = 4'd11,
      OP_OR     = 4'd12, OP_MULT  = 4'd13, OP_CLR   = 4'd14, OP_NOT   = 4'd15
   } cop_e;

   typedef enum logic [1:0] {SK_LSL = 2'd0, SK_LSR = 2'd1, SK_ASR = 2'd2, SK_ROR = 2'd3} shkind_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   localparam int OPSEL_LSB = 6;
   localparam int RA_LSB    = 0;
   localparam int RB_LSB    = 3;

   function automatic logic is_shift(cop_e op);
      return op inside {OP_SHL, OP_SHR, OP_SAR, OP_ROT};
   endfunction

   function automatic logic is_flag_only(cop_e op);
      return op inside {OP_TEST, OP_COMP, OP_COMPN};
   endfunction
endpackage

// File: rtl/cmpx_shifter.sv
module cmpx_shifter
   import cmpx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] val,
   input  logic [AMT_W-1:0]  amt,
   input  shkind_e           kind,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int RW = $clog2(DATA_W);

   if (DATA_W >= (1 << AMT_W)) begin : g_bad_amt
      $error("shift amount field too narrow for DATA_W");
   end

   logic [DATA_W:0]          wl, wr;
   logic signed [DATA_W:0]   ws, wa;
   logic [AMT_W-1:0]         sat;
   logic [2*DATA_W-1:0]      rot_pair;
   logic [DATA_W-1:0]        unused_rot;

   assign wl       = {1'b0, val} << amt;
   assign wr       = {val, 1'b0} >> amt;
   assign sat      = (amt >= AMT_W'(DATA_W)) ? AMT_W'(DATA_W) : amt;
   assign ws       = {val, 1'b0};
   assign wa       = ws >>> sat;
   assign rot_pair = {val, val} >> amt[RW-1:0];
   assign unused_rot = rot_pair[2*DATA_W-1:DATA_W];

   always_comb begin
      res  = val;
      cout = cin;
      if (amt != '0) begin
         unique case (kind)
            SK_LSL: begin res = wl[DATA_W-1:0]; cout = wl[DATA_W]; end
            SK_LSR: begin res = wr[DATA_W:1];   cout = wr[0];      end
            SK_ASR: begin res = wa[DATA_W:1];   cout = wa[0];      end
            default: begin
               res  = rot_pair[DATA_W-1:0];
               cout = rot_pair[DATA_W-1];
            end
         endcase
      end
   end
endmodule

// File: rtl/cmpx_addsub.sv
module cmpx_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   logic [DATA_W:0] full;

   assign full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
   assign sum  = full[DATA_W-1:0];
   assign cout = full[DATA_W];
   assign ovf  = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
endmodule

// File: rtl/cmpx_cost.sv
module cmpx_cost
   import cmpx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MUL_FIXED = 3,
   parameter int CYC_W     = 4
) (
   input  cop_e              op,
   input  logic              variant,
   input  logic [DATA_W-1:0] mul_a,
   output logic [CYC_W-1:0]  cycles
);
   localparam int NB  = DATA_W / 8;
   localparam int NBW = (NB > 1) ? $clog2(NB) : 1;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if ((1 << CYC_W) <= NB + MUL_FIXED + 1) begin : g_bad_cyc
      $error("CYC_W too narrow for the largest cost");
   end

   logic [NB-1:0]  lane_nz;
   logic [NBW-1:0] hi_lane;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign lane_nz[i] = |mul_a[8*i +: 8];
   end

   always_comb begin
      hi_lane = '0;
      for (int i = 0; i < NB; i++) begin
         if (lane_nz[i]) hi_lane = NBW'(i);
      end
   end

   always_comb begin
      if (is_shift(op))        cycles = CYC_W'(2);
      else if (op == OP_MULT)  cycles = variant ? CYC_W'(hi_lane) + CYC_W'(2)
                                                : CYC_W'(1 + MUL_FIXED);
      else                     cycles = CYC_W'(1);
   end
endmodule

// File: rtl/cmpx_alu_exec.sv
module cmpx_alu_exec
   import cmpx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int INSTR_W   = 16,
   parameter int IDX_W     = 3,
   parameter int AMT_W     = 8,
   parameter int MUL_FIXED = 3,
   localparam int CYC_W    = $clog2(DATA_W / 8 + MUL_FIXED + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [INSTR_W-1:0] instr,
   input  logic               variant,
   input  logic [3:0]         flags_in,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   output logic [IDX_W-1:0]   ra_idx,
   output logic [IDX_W-1:0]   rb_idx,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  result,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [3:0]         flags_out,
   output logic [CYC_W-1:0]   cycles
);
   localparam int USED_W = OPSEL_LSB + 4;

   if (INSTR_W < USED_W) begin : g_bad_instr
      $error("instruction too narrow for the operation field");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be at least 16");
   end

   cop_e               op;
   shkind_e            skind;
   logic [DATA_W-1:0]  sh_res, add_x, add_y, add_sum, mul_lo, nxt_res;
   logic               sh_c, add_ci, add_co, add_ov, nxt_c, nxt_v;
   logic [CYC_W-1:0]   nxt_cyc;
   logic [INSTR_W-USED_W-1:0] unused_hi;

   assign op        = cop_e'(instr[OPSEL_LSB +: 4]);
   assign ra_idx    = instr[RA_LSB +: IDX_W];
   assign rb_idx    = instr[RB_LSB +: IDX_W];
   assign req_ready = 1'b1;
   assign unused_hi = instr[INSTR_W-1:USED_W];
   assign mul_lo    = opa * opb;

   always_comb begin
      unique case (op)
         OP_SHL:  skind = SK_LSL;
         OP_SHR:  skind = SK_LSR;
         OP_SAR:  skind = SK_ASR;
         default: skind = SK_ROR;
      endcase
   end

   cmpx_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .val(opa), .amt(opb[AMT_W-1:0]), .kind(skind), .cin(flags_in[FLG_C]),
      .res(sh_res), .cout(sh_c));

   always_comb begin
      add_x  = opa;
      add_y  = opb;
      add_ci = 1'b0;
      case (op)
         OP_ADDC:   add_ci = flags_in[FLG_C];
         OP_SUBC:   begin add_y = ~opb; add_ci = flags_in[FLG_C]; end
         OP_COMP:   begin add_y = ~opb; add_ci = 1'b1; end
         OP_NEGATE: begin add_x = '0; add_y = ~opb; add_ci = 1'b1; end
         default:   ;
      endcase
   end

   cmpx_addsub #(.DATA_W(DATA_W)) u_add (
      .x(add_x), .y(add_y), .cin(add_ci), .sum(add_sum), .cout(add_co), .ovf(add_ov));

   cmpx_cost #(.DATA_W(DATA_W), .MUL_FIXED(MUL_FIXED), .CYC_W(CYC_W)) u_cost (
      .op(op), .variant(variant), .mul_a(opa), .cycles(nxt_cyc));

   always_comb begin
      nxt_c = flags_in[FLG_C];
      nxt_v = flags_in[FLG_V];
      unique case (op)
         OP_AND, OP_TEST: nxt_res = opa & opb;
         OP_XOR:          nxt_res = opa ^ opb;
         OP_OR:           nxt_res = opa | opb;
         OP_CLR:          nxt_res = opa & ~opb;
         OP_NOT:          nxt_res = ~opb;
         OP_SHL, OP_SHR, OP_SAR, OP_ROT: begin
            nxt_res = sh_res;
            nxt_c   = sh_c;
         end
         OP_MULT: begin
            nxt_res = mul_lo;
            if (variant) nxt_c = 1'b0;
         end
         default: begin
            nxt_res = add_sum;
            nxt_c   = add_co;
            nxt_v   = add_ov;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         wr_en     <= 1'b0;
         result    <= '0;
         wr_idx    <= '0;
         flags_out <= '0;
         cycles    <= '0;
      end else begin
         rsp_valid <= req_valid;
         wr_en     <= req_valid && !is_flag_only(op);
         if (req_valid) begin
            result    <= nxt_res;
            wr_idx    <= ra_idx;
            flags_out <= {nxt_res[DATA_W-1], nxt_res == '0, nxt_c, nxt_v};
            cycles    <= nxt_cyc;
         end
      end
   end

   AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !wr_en)); // R10
   AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op inside {OP_TEST, OP_COMP, OP_COMPN}) |=> !wr_en); // R5
   AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op inside {OP_AND, OP_XOR, OP_OR, OP_CLR, OP_NOT, OP_TEST, OP_MULT})
      |=> flags_out[FLG_V] == $past(flags_in[FLG_V])); // R6
   AST_MUL_V1_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_MULT && variant) |=> !flags_out[FLG_C]); // R9
   AST_MUL_V0_COST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_MULT && !variant) |=> cycles == CYC_W'(1 + MUL_FIXED)); // R8
   AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_shift(op) && opb[AMT_W-1:0] == '0)
      |=> (result == $past(opa) && flags_out[FLG_C] == $past(flags_in[FLG_C]))); // R11
endmodule

// File: tb/tb_cmpx_alu_exec.sv
module tb_cmpx_alu_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] instr = '0;
   logic        variant = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [31:0] opa = '0, opb = '0;
   logic [2:0]  ra_idx, rb_idx, wr_idx;
   logic        rsp_valid, wr_en;
   logic [31:0] result;
   logic [3:0]  flags_out;
   logic [3:0]  cycles;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cmpx_alu_exec dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .instr(instr), .variant(variant), .flags_in(flags_in), .opa(opa), .opb(opb),
      .ra_idx(ra_idx), .rb_idx(rb_idx), .rsp_valid(rsp_valid), .result(result),
      .wr_en(wr_en), .wr_idx(wr_idx), .flags_out(flags_out), .cycles(cycles));

   typedef struct {
      logic [31:0] res;
      logic        wr;
      logic [2:0]  idx;
      logic [3:0]  fl;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t pending[$];

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string op_tag(int op, bit v);
      if (op == 13) return v ? "R9" : "R8";
      if (op inside {2, 3, 4, 7}) return "R3";
      if (op inside {5, 6, 9, 10, 11}) return "R4";
      return "R1";
   endfunction

   function automatic exp_t model(int op, logic [31:0] a, logic [31:0] b,
                                  logic [3:0] fl, bit v, logic [2:0] rd);
      exp_t e;
      int n;
      int m;
      logic c;
      logic ov;
      longint sa, sb, sr, ua, ub, ur;
      logic [31:0] r;
      n  = int'(b[7:0]);
      c  = fl[1];
      ov = fl[0];
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = longint'({32'd0, a});
      ub = longint'({32'd0, b});
      r  = '0;
      case (op)
         0, 8: r = a & b;
         1:    r = a ^ b;
         12:   r = a | b;
         14:   r = a & ~b;
         15:   r = ~b;
         13: begin r = a * b; if (v) c = 1'b0; end
         2: begin
            if (n == 0) r = a;
            else if (n < 32) begin r = a << n; c = a[32 - n]; end
            else if (n == 32) begin r = 0; c = a[0]; end
            else begin r = 0; c = 1'b0; end
         end
         3: begin
            if (n == 0) r = a;
            else if (n < 32) begin r = a >> n; c = a[n - 1]; end
            else if (n == 32) begin r = 0; c = a[31]; end
            else begin r = 0; c = 1'b0; end
         end
         4: begin
            if (n == 0) r = a;
            else if (n < 32) begin r = $unsigned($signed(a) >>> n); c = a[n - 1]; end
            else begin r = {32{a[31]}}; c = a[31]; end
         end
         7: begin
            if (n == 0) r = a;
            else begin
               m = n % 32;
               if (m == 0) r = a;
               else r = (a >> m) | (a << (32 - m));
               c = r[31];
            end
         end
         default: begin
            case (op)
               5:  begin ur = ua + ub + longint'(fl[1]);       sr = sa + sb + longint'(fl[1]); end
               6:  begin ur = ua - ub - longint'(!fl[1]);      sr = sa - sb - longint'(!fl[1]); end
               10: begin ur = ua - ub;                         sr = sa - sb; end
               11: begin ur = ua + ub;                         sr = sa + sb; end
               default: begin ur = 0 - ub;                     sr = 0 - sb; end
            endcase
            r = ur[31:0];
            if (op inside {5, 11}) c = ur > 64'sd4294967295;
            else c = ur >= 0;
            ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
         end
      endcase
      e.res = r;
      e.wr  = !(op inside {8, 10, 11});
      e.idx = rd;
      e.fl  = {r[31], r == 32'd0, c, ov};
      if (op inside {2, 3, 4, 7}) e.cyc = 2;
      else if (op == 13) begin
         if (!v) e.cyc = 4;
         else if (a[31:24] != 0) e.cyc = 5;
         else if (a[23:16] != 0) e.cyc = 4;
         else if (a[15:8] != 0) e.cyc = 3;
         else e.cyc = 2;
      end else e.cyc = 1;
      e.tag = op_tag(op, v);
      return e;
   endfunction

   task automatic compare_cycle();
      exp_t e;
      if (pending.size() == 0) begin
         check("R10", "idle rsp_valid", 64'(rsp_valid), 64'd0);
         check("R10", "idle wr_en", 64'(wr_en), 64'd0);
      end else begin
         e = pending.pop_front();
         check("R10", "rsp_valid", 64'(rsp_valid), 64'd1);
         check(e.tag, "result", 64'(result), 64'(e.res));
         check("R5", "wr_en", 64'(wr_en), 64'(e.wr));
         check("R2", "wr_idx", 64'(wr_idx), 64'(e.idx));
         check(e.tag == "R1" ? "R6" : e.tag, "flags", 64'(flags_out), 64'(e.fl));
         check(e.tag == "R1" ? "R7" : e.tag, "cycles", 64'(cycles), 64'(e.cyc));
      end
   endtask

   task automatic issue(int op, logic [2:0] rd, logic [2:0] rs, logic [31:0] a,
                        logic [31:0] b, logic [3:0] fl, bit v);
      instr     = {6'b010000, 4'(op), rs, rd};
      opa       = a;
      opb       = b;
      flags_in  = fl;
      variant   = v;
      req_valid = 1'b1;
      #1;
      check("R2", "ra_idx", 64'(ra_idx), 64'(rd));
      check("R2", "rb_idx", 64'(rb_idx), 64'(rs));
      check("R10", "req_ready", 64'(req_ready), 64'd1);
      pending.push_back(model(op, a, b, fl, v, rd));
      @(posedge clk);
      #2;
      compare_cycle();
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(posedge clk);
      #2;
      compare_cycle();
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
      check("R10", "reset wr_en", 64'(wr_en), 64'd0);
      check("R10", "reset result", 64'(result), 64'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      // R1 logical ops and R6 flag keeping
      issue(0, 3'd1, 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011, 0);
      issue(1, 3'd2, 3'd3, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0001, 0);
      issue(12, 3'd7, 3'd0, 32'h8000_0000, 32'h0000_0001, 4'b0000, 0);
      issue(14, 3'd4, 3'd5, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0010, 0);
      issue(15, 3'd6, 3'd6, 32'h0, 32'h0, 4'b0001, 0);
      // R5 flag-only ops
      issue(8, 3'd0, 3'd1, 32'h1234_0000, 32'h0000_5678, 4'b0011, 0);
      issue(10, 3'd3, 3'd4, 32'h5, 32'h5, 4'b0000, 0);
      issue(11, 3'd5, 3'd2, 32'h7FFF_FFFF, 32'h1, 4'b0000, 0);
      idle();
      // R3 / R11 shifts and corner amounts
      issue(2, 3'd1, 3'd0, 32'h8000_0001, 32'h0000_0100, 4'b0010, 0);
      issue(2, 3'd1, 3'd0, 32'h8000_0001, 32'h1, 4'b0000, 0);
      issue(2, 3'd1, 3'd0, 32'h0000_0003, 32'd31, 4'b0000, 0);
      issue(2, 3'd1, 3'd0, 32'h0000_0001, 32'd32, 4'b0000, 0);
      issue(2, 3'd1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0121, 4'b0010, 0);
      issue(3, 3'd2, 3'd1, 32'h8000_0000, 32'd32, 4'b0000, 0);
      issue(3, 3'd2, 3'd1, 32'h8000_0000, 32'd33, 4'b0010, 0);
      issue(3, 3'd2, 3'd1, 32'h0000_0002, 32'd2, 4'b0000, 0);
      issue(4, 3'd3, 3'd1, 32'h8000_0000, 32'd40, 4'b0000, 0);
      issue(4, 3'd3, 3'd1, 32'h4000_0000, 32'd255, 4'b0010, 0);
      issue(4, 3'd3, 3'd1, 32'hF000_0000, 32'd4, 4'b0000, 0);
      issue(7, 3'd4, 3'd1, 32'h8000_0001, 32'd32, 4'b0000, 0);
      issue(7, 3'd4, 3'd1, 32'h0000_0010, 32'd36, 4'b0000, 0);
      issue(7, 3'd4, 3'd1, 32'h1234_5678, 32'h0000_FF00, 4'b0010, 0);
      // R4 arithmetic
      issue(5, 3'd0, 3'd1, 32'h7FFF_FFFF, 32'h0, 4'b0010, 0);
      issue(5, 3'd0, 3'd1, 32'hFFFF_FFFF, 32'h0, 4'b0010, 0);
      issue(6, 3'd0, 3'd1, 32'h0, 32'h0, 4'b0000, 0);
      issue(6, 3'd0, 3'd1, 32'h8000_0000, 32'h0, 4'b0000, 0);
      issue(6, 3'd0, 3'd1, 32'h5, 32'h3, 4'b0010, 0);
      issue(10, 3'd0, 3'd1, 32'h8000_0000, 32'h1, 4'b0000, 0);
      issue(11, 3'd0, 3'd1, 32'hFFFF_FFFF, 32'h1, 4'b0000, 0);
      issue(9, 3'd0, 3'd1, 32'h0, 32'h0, 4'b0000, 0);
      issue(9, 3'd0, 3'd1, 32'h0, 32'h8000_0000, 4'b0000, 0);
      issue(9, 3'd0, 3'd1, 32'h0, 32'h1, 4'b0011, 0);
      idle();
      // R8 / R9 multiply
      issue(13, 3'd2, 3'd3, 32'h0100_0000, 32'h3, 4'b0010, 0);
      issue(13, 3'd2, 3'd3, 32'h0100_0000, 32'h3, 4'b0010, 1);
      issue(13, 3'd2, 3'd3, 32'h0001_0000, 32'hFFFF, 4'b0010, 1);
      issue(13, 3'd2, 3'd3, 32'h0000_0100, 32'h10, 4'b0010, 1);
      issue(13, 3'd2, 3'd3, 32'h0000_00FF, 32'hFFFF_FFFF, 4'b0011, 1);
      issue(13, 3'd2, 3'd3, 32'h0, 32'h1234, 4'b0010, 1);
      idle();
      idle();
      // mixed patterns, all requirements
      for (int k = 0; k < 600; k++) begin
         int op;
         logic [31:0] a, b;
         op = int'($urandom_range(15, 0));
         a  = $urandom;
         b  = $urandom;
         if (k % 3 == 0) a = a >> (8 * (k % 4));
         if (op inside {2, 3, 4, 7} && k % 2 == 0) b = {b[31:8], 8'($urandom_range(40, 0))};
         issue(op, 3'($urandom), 3'($urandom), a, b, 4'($urandom), bit'($urandom));
         if (k % 9 == 0) idle();
      end
      idle();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule